// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Status Register

This block gathers the three interrupt causes of a real-time clock and turns them into a readable status byte and an active-low interrupt request. The three causes are a rising edge on the chosen tap of the clock's divider, a pulse from the alarm comparator when the time matches the alarm setting, and a pulse at the end of each time-keeping update. Each cause latches its own sticky flag, whether or not its enable is set. A master flag combines the flags through their enables, and it drives the request pin low.

Software learns about an event by reading the status byte. A read of that byte returns the flags as they stood, then clears all of them together. A second byte reports whether backup power is good. Reading it changes nothing. The divider, the counters, the alarm comparator and the bus decoding sit outside this block and appear here only as pulses, a tap level and a read strobe with a select.

Top module: `rtc_irq_status`

## Requirements
- R1: A synchronous active-high reset clears all flags, so `status_o` reads 0x00, `rd_data_o` reads 0x00 and `irq_n_o` is 1 on the first cycle after reset.
- R2: An alarm pulse sets status bit 5 on the next clock edge, whatever the enables are.
- R3: An update-ended pulse sets status bit 4 on the next clock edge, whatever the enables are.
- R4: A 0-to-1 change of `tap_i` sets status bit 6 on the edge that first samples the high level, whatever the enables are. A steady level does not set it, and a 1-to-0 change does not set it.
- R5: Status bit 7 equals (bit6 AND periodic enable) OR (bit5 AND alarm enable) OR (bit4 AND update enable). Bits 3..0 always read 0.
- R6: `irq_n_o` is 0 exactly when status bit 7 is 1. It follows enable changes in the same cycle.
- R7: A status read is a cycle with `rd_stb_i`=1 and `rd_sel_i`=0. It loads `rd_data_o` at that edge with the status byte before the clear, and it clears all flags at the same edge. `rd_data_o` holds its value between reads.
- R8: A set event that arrives in the same cycle as a status read leaves its flag set after the read.
- R9: A validity read is a cycle with `rd_stb_i`=1 and `rd_sel_i`=1. It loads `rd_data_o` with `{batt_ok_i, 7'b0}` and leaves every flag unchanged.
- R10: `valid_o` is `{batt_ok_i, 7'b0}` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tap_i | input | 1 | Level of the selected divider tap |
| alarm_hit_i | input | 1 | Alarm match pulse |
| update_done_i | input | 1 | Update-ended pulse |
| en_periodic_i | input | 1 | Periodic interrupt enable |
| en_alarm_i | input | 1 | Alarm interrupt enable |
| en_update_i | input | 1 | Update-ended interrupt enable |
| rd_stb_i | input | 1 | Register read strobe |
| rd_sel_i | input | 1 | Read select: 0 = status byte, 1 = validity byte |
| batt_ok_i | input | 1 | Backup power good level |
| status_o | output | 8 | Live status byte |
| valid_o | output | 8 | Live validity byte |
| rd_data_o | output | 8 | Byte captured by the last read |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach from the ports is a status read that lands in the same cycle as one or more set events. That case must both report the old byte and keep the new flag. The stimulus reaches it by lining up an alarm pulse with a status read while other flags are already pending. It then fires all three causes, including a fresh tap edge, on the same cycle as a read. A validity read is also placed while flags are pending, to show that only the status read clears them.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int BYTE_W     = 8;
  localparam int NSRC       = 3;
  localparam int FLAG_LSB   = 4;
  localparam int MASTER_BIT = 7;
  localparam int VALID_BIT  = 7;

  // Flag vector index order matches status bits FLAG_LSB upward.
  localparam int IDX_UPD = 0;
  localparam int IDX_ALM = 1;
  localparam int IDX_PER = 2;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_VALID = 1'b1} rd_sel_e;

  function automatic logic master_of(input logic [NSRC-1:0] flags,
                                     input logic [NSRC-1:0] en);
    return |(flags & en);
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic master,
                                                    input logic [NSRC-1:0] flags);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[MASTER_BIT] = master;
    b[FLAG_LSB +: NSRC] = flags;
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_valid(input logic ok);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[VALID_BIT] = ok;
    return b;
  endfunction
endpackage

// File: rtl/rtc_tap_edge.sv
module rtc_tap_edge (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tap_i,
  output logic rise_o
);
  logic tap_q;

  always_ff @(posedge clk_i) begin
    tap_q <= tap_i;
  end

  assign rise_o = tap_i & ~tap_q;

  // A rising edge cannot be reported on two cycles in a row.
  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o);  // R4
endmodule

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // A set wins over a clear in the same cycle.
  always_ff @(posedge clk_i) begin
    if (rst_i)      flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (rst_i)
    set_i |=> flag_o);  // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !set_i) |=> !flag_o);  // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_i && !set_i) |=> $stable(flag_o));  // R9
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tap_i,
  input  logic              alarm_hit_i,
  input  logic              update_done_i,
  input  logic              en_periodic_i,
  input  logic              en_alarm_i,
  input  logic              en_update_i,
  input  logic              rd_stb_i,
  input  logic              rd_sel_i,
  input  logic              batt_ok_i,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] valid_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              irq_n_o
);
  logic              tap_rise;
  logic [NSRC-1:0]   set_vec;
  logic [NSRC-1:0]   en_vec;
  logic [NSRC-1:0]   flags;
  logic              master;
  logic              rd_status;
  logic              rd_valid;
  logic [BYTE_W-1:0] rd_q;

  rtc_tap_edge u_edge (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tap_i  (tap_i),
    .rise_o (tap_rise)
  );

  assign set_vec[IDX_UPD] = update_done_i;
  assign set_vec[IDX_ALM] = alarm_hit_i;
  assign set_vec[IDX_PER] = tap_rise;
  assign en_vec[IDX_UPD]  = en_update_i;
  assign en_vec[IDX_ALM]  = en_alarm_i;
  assign en_vec[IDX_PER]  = en_periodic_i;

  assign rd_status = rd_stb_i && (rd_sel_e'(rd_sel_i) == SEL_STATUS);
  assign rd_valid  = rd_stb_i && (rd_sel_e'(rd_sel_i) == SEL_VALID);

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    rtc_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .set_i  (set_vec[g]),
      .clr_i  (rd_status),
      .flag_o (flags[g])
    );
  end

  assign master   = master_of(flags, en_vec);
  assign status_o = pack_status(master, flags);
  assign valid_o  = pack_valid(batt_ok_i);
  assign irq_n_o  = ~master;

  // Read data is captured from the pre-clear status at the read edge.
  always_ff @(posedge clk_i) begin
    if (rst_i)          rd_q <= '0;
    else if (rd_status) rd_q <= status_o;
    else if (rd_valid)  rd_q <= valid_o;
  end

  assign rd_data_o = rd_q;

  AST_READ_PRECLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_status |=> rd_data_o == $past(status_o));  // R7
  AST_VALID_READ: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_valid |=> rd_data_o == $past(valid_o));  // R9
  AST_VALID_KEEPS: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_valid && set_vec == '0) |=> flags == $past(flags));  // R9
  AST_PIN_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_vec == '0) |-> irq_n_o);  // R6
  AST_NIBBLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_data_o[FLAG_LSB-1:0] == '0);  // R5
endmodule

// File: tb/tb_rtc_irq_status.sv
module tb_rtc_irq_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tap = 1'b0, alm = 1'b0, upd = 1'b0;
  logic en_p = 1'b0, en_a = 1'b0, en_u = 1'b0;
  logic rd_stb = 1'b0, rd_sel = 1'b0, batt = 1'b1;
  logic [7:0] status, valid, rd_data;
  logic irq_n;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rtc_irq_status dut (
    .clk_i(clk), .rst_i(rst), .tap_i(tap), .alarm_hit_i(alm),
    .update_done_i(upd), .en_periodic_i(en_p), .en_alarm_i(en_a),
    .en_update_i(en_u), .rd_stb_i(rd_stb), .rd_sel_i(rd_sel),
    .batt_ok_i(batt), .status_o(status), .valid_o(valid),
    .rd_data_o(rd_data), .irq_n_o(irq_n)
  );

  // {alm,upd,tap, en_p,en_a,en_u, rd_stb,rd_sel,batt, status, rd_data, irq_n}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {3'b000, 3'b000, 3'b001, 8'h00, 8'h00, 1'b1},  // R1 idle after reset
    {3'b100, 3'b000, 3'b001, 8'h20, 8'h00, 1'b1},  // R2 alarm, not enabled
    {3'b000, 3'b010, 3'b001, 8'hA0, 8'h00, 1'b0},  // R5 enable alarm
    {3'b000, 3'b010, 3'b101, 8'h00, 8'hA0, 1'b1},  // R7 status read
    {3'b010, 3'b000, 3'b001, 8'h10, 8'hA0, 1'b1},  // R3 update, not enabled
    {3'b000, 3'b001, 3'b001, 8'h90, 8'hA0, 1'b0},  // R6 enable update
    {3'b001, 3'b001, 3'b001, 8'hD0, 8'hA0, 1'b0},  // R4 tap rises
    {3'b001, 3'b001, 3'b111, 8'hD0, 8'h80, 1'b0},  // R9 validity read, tap steady
    {3'b000, 3'b100, 3'b001, 8'hD0, 8'h80, 1'b0},  // R4 tap falls, no set
    {3'b100, 3'b100, 3'b101, 8'h20, 8'hD0, 1'b1},  // R8 alarm during read
    {3'b000, 3'b000, 3'b101, 8'h00, 8'h20, 1'b1},  // R7 read returns kept alarm
    {3'b000, 3'b000, 3'b110, 8'h00, 8'h00, 1'b1}   // R9 validity read, battery bad
  };
  localparam int TAG [NV] = '{1, 2, 5, 7, 3, 6, 4, 9, 4, 8, 7, 9};

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alm = 1'b0; upd = 1'b0; rd_stb = 1'b0;
  endtask

  initial begin : watchdog
    while (cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=<5000 cycles", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      string tg;
      {alm, upd, tap, en_p, en_a, en_u, rd_stb, rd_sel, batt} = VEC[i][25:17];
      @(negedge clk);
      tg = $sformatf("R%0d", TAG[i]);
      chk(tg, "status", status, VEC[i][16:9]);
      chk(tg, "rd_data", rd_data, VEC[i][8:1]);
      chk(tg, "irq_n", {7'b0, irq_n}, {7'b0, VEC[i][0]});
    end
    idle_inputs();

    // R10: validity byte follows the battery level
    batt = 1'b0; #1;
    chk("R10", "valid low", valid, 8'h00);
    batt = 1'b1; #1;
    chk("R10", "valid high", valid, 8'h80);

    // R8: all three causes on the same cycle as a status read
    @(negedge clk);
    tap = 1'b0;
    @(negedge clk);
    en_p = 1'b1; en_a = 1'b1; en_u = 1'b1;
    alm = 1'b1; upd = 1'b1; tap = 1'b1; rd_stb = 1'b1; rd_sel = 1'b0;
    @(negedge clk);
    idle_inputs();
    chk("R8", "status", status, 8'hF0);
    chk("R7", "rd_data", rd_data, 8'h00);
    chk("R6", "irq_n", {7'b0, irq_n}, 8'h00);

    // R6: dropping enables releases the pin in the same cycle
    en_p = 1'b0; en_a = 1'b0; en_u = 1'b0; #1;
    chk("R6", "irq_n no enable", {7'b0, irq_n}, 8'h01);
    chk("R5", "status no enable", status, 8'h70);

    // R1: reset while flags are pending
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    en_a = 1'b1; #1;
    chk("R1", "status", status, 8'h00);
    chk("R1", "rd_data", rd_data, 8'h00);
    chk("R1", "irq_n", {7'b0, irq_n}, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule